// File: doc/BRIEF.md
# Shift and Integer ALU Execute Unit

This block is the combinational execute stage for register-format integer instructions in a 32-bit pipeline. Decode hands it the 6-bit function code, the three register numbers, the immediate shift amount, one rotate-select bit and the two source operand values. In the same cycle it returns the result word, a write-enable for the destination register, a no-op classification and an overflow-trap flag.

The supported operations are shifts by an immediate or a register amount (logical left, logical right, arithmetic right), rotate right, add and subtract with and without an overflow trap, the four bitwise operations, signed and unsigned compare-to-flag, and the two conditional moves. Register-file access, pipeline interlocks, exception sequencing and multiply/divide are handled elsewhere. The rotate-select input is driven by decode from whichever instruction bit selects rotation for the function in use.

Top module: `shift_alu_exec`

## Requirements
- R1: Function 0x00 returns rt_val shifted left by shamt, zero-filled.
- R2: When function is 0x00 and rs_idx, rt_idx and rd_idx are all zero, nop_kind reports 2 (superscalar no-op) for shamt 1, 3 (hazard barrier) for shamt 3 and 1 (plain no-op) for any other shamt; in every other case nop_kind is 0 and no write occurs for a no-op.
- R3: Function 0x02 returns rt_val shifted right logically by shamt when rot_sel is 0, and rt_val rotated right by shamt when rot_sel is 1.
- R4: Function 0x06 returns rt_val shifted right logically by the register amount when rot_sel is 0, and rotated right by that amount when rot_sel is 1.
- R5: The register-amount shifts (0x04 left, 0x06, 0x07) use only the low 5 bits of rs_val as the amount; function 0x04 returns rt_val shifted left by that amount.
- R6: Arithmetic right shifts (0x03 by shamt, 0x07 by register amount) fill the vacated upper bits with rt_val bit 31.
- R7: Functions 0x20/0x21 return rs_val + rt_val and 0x22/0x23 return rs_val - rt_val, modulo 2^32.
- R8: ovf_trap is 1 only for 0x20 and 0x22 when the signed result overflows 32 bits; when it is 1, wr_en is 0.
- R9: Functions 0x24, 0x25, 0x26, 0x27 return AND, OR, XOR and NOR of rs_val and rt_val.
- R10: Function 0x2A returns 1 if rs_val < rt_val as signed numbers, else 0; 0x2B does the same unsigned.
- R11: Function 0x0A returns rs_val with wr_en 1 only when rt_val is zero; 0x0B only when rt_val is non-zero; otherwise wr_en is 0.
- R12: A rotate by amount zero returns rt_val unchanged.
- R13: wr_en is 0 whenever rd_idx is zero.
- R14: Any other function code gives result 0, wr_en 0, ovf_trap 0; valid operations with rd_idx non-zero and no trap give wr_en 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| funct | input | 6 | Function code of the instruction |
| rs_idx | input | 5 | First source register number |
| rt_idx | input | 5 | Second source register number |
| rd_idx | input | 5 | Destination register number |
| shamt | input | 5 | Immediate shift amount |
| rot_sel | input | 1 | Selects rotate instead of logical right shift for 0x02 and 0x06 |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand |
| result | output | 32 | Computed result |
| wr_en | output | 1 | Destination write enable |
| nop_kind | output | 2 | 0 none, 1 plain no-op, 2 superscalar no-op, 3 hazard barrier |
| ovf_trap | output | 1 | Signed overflow trap for the trapping add and subtract |

## Verification
The sweep crosses every function code with operands at the signed and unsigned extremes, so a design that took the overflow condition from the carry would trap on unsigned wraps such as 0xFFFFFFFF + 1, and one that trapped on the unsigned forms would be caught at 0x7FFFFFFF + 1. Register amounts come from operands with set upper bits, so a shifter using the full rs_val would return zero instead of the expected shift. Rotate by zero and by 31 exposes a rotate built from a left shift by 32 minus the amount, and an arithmetic shift of 0x80000000 exposes a missing sign fill. The all-zero shift-left forms are swept across every amount to catch a misclassified no-op, and rd_idx zero is crossed with every operation to catch a leaked write.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_SLLV = 6'h04;
    localparam logic [5:0] FN_SRLV = 6'h06;
    localparam logic [5:0] FN_SRAV = 6'h07;
    localparam logic [5:0] FN_MOVZ = 6'h0A;
    localparam logic [5:0] FN_MOVN = 6'h0B;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        OP_NONE, OP_SHL, OP_SHR, OP_SAR, OP_ROR,
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
        OP_SLT, OP_SLTU, OP_MOVZ, OP_MOVN
    } op_e;

    typedef enum logic [1:0] {
        NOP_NONE    = 2'd0,
        NOP_PLAIN   = 2'd1,
        NOP_SUPER   = 2'd2,
        NOP_BARRIER = 2'd3
    } nop_e;

    typedef struct packed {
        op_e  op;
        logic reg_amt;
        logic trap_en;
    } dec_t;

    function automatic logic is_shift(op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR) || (op == OP_ROR);
    endfunction

    function automatic logic is_alu(op_e op);
        return (op >= OP_ADD) && (op <= OP_SLTU);
    endfunction

endpackage

// File: rtl/shift_alu_decode.sv
module shift_alu_decode
    import shift_alu_pkg::*;
#(
    parameter int FUNC_W = 6,
    parameter int RIDX_W = 5,
    parameter int SHW    = 5
) (
    input  logic [FUNC_W-1:0] funct,
    input  logic              rot_sel,
    input  logic [RIDX_W-1:0] rs_idx,
    input  logic [RIDX_W-1:0] rt_idx,
    input  logic [RIDX_W-1:0] rd_idx,
    input  logic [SHW-1:0]    shamt,
    output dec_t              dec,
    output nop_e              nop_kind
);
    localparam logic [SHW-1:0] AMT_SUPER   = SHW'(1);
    localparam logic [SHW-1:0] AMT_BARRIER = SHW'(3);

    always_comb begin
        dec = '{op: OP_NONE, reg_amt: 1'b0, trap_en: 1'b0};
        unique case (6'(funct))
            FN_SLL:  dec.op = OP_SHL;
            FN_SRL:  dec.op = rot_sel ? OP_ROR : OP_SHR;
            FN_SRA:  dec.op = OP_SAR;
            FN_SLLV: begin dec.op = OP_SHL; dec.reg_amt = 1'b1; end
            FN_SRLV: begin dec.op = rot_sel ? OP_ROR : OP_SHR; dec.reg_amt = 1'b1; end
            FN_SRAV: begin dec.op = OP_SAR; dec.reg_amt = 1'b1; end
            FN_MOVZ: dec.op = OP_MOVZ;
            FN_MOVN: dec.op = OP_MOVN;
            FN_ADD:  begin dec.op = OP_ADD; dec.trap_en = 1'b1; end
            FN_ADDU: dec.op = OP_ADD;
            FN_SUB:  begin dec.op = OP_SUB; dec.trap_en = 1'b1; end
            FN_SUBU: dec.op = OP_SUB;
            FN_AND:  dec.op = OP_AND;
            FN_OR:   dec.op = OP_OR;
            FN_XOR:  dec.op = OP_XOR;
            FN_NOR:  dec.op = OP_NOR;
            FN_SLT:  dec.op = OP_SLT;
            FN_SLTU: dec.op = OP_SLTU;
            default: dec.op = OP_NONE;
        endcase
    end

    // Zero-register shift-left forms are classified by their amount.
    always_comb begin
        nop_kind = NOP_NONE;
        if (6'(funct) == FN_SLL && rs_idx == '0 && rt_idx == '0 && rd_idx == '0) begin
            if (shamt == AMT_SUPER)
                nop_kind = NOP_SUPER;
            else if (shamt == AMT_BARRIER)
                nop_kind = NOP_BARRIER;
            else
                nop_kind = NOP_PLAIN;
        end
    end
endmodule

// File: rtl/shift_alu_shifter.sv
module shift_alu_shifter
    import shift_alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  op_e              op,
    input  logic [SHW-1:0]   amt,
    input  logic [XLEN-1:0]  val,
    output logic [XLEN-1:0]  res
);
    logic [XLEN-1:0] shl, shr, sar, ror;

    assign shl = val << amt;
    assign shr = val >> amt;
    assign sar = $unsigned($signed(val) >>> amt);
    // Rotation slides a doubled word, so amount zero never needs a full-width shift.
    assign ror = XLEN'({val, val} >> amt);

    always_comb begin
        unique case (op)
            OP_SHL:  res = shl;
            OP_SHR:  res = shr;
            OP_SAR:  res = sar;
            OP_ROR:  res = ror;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/shift_alu_arith.sv
module shift_alu_arith
    import shift_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            ovf
);
    localparam int MSB = XLEN - 1;

    logic            subtract;
    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   sum_ext;
    logic [XLEN-1:0] sum;
    logic            lt_signed, lt_unsigned;

    assign subtract = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    assign b_eff    = subtract ? ~b : b;
    assign sum_ext  = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, subtract};
    assign sum      = sum_ext[XLEN-1:0];

    // Signed overflow: operands agree in sign and the sum does not.
    assign ovf = ((op == OP_ADD) || (op == OP_SUB))
               && (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

    // Unsigned borrow is the missing carry-out of a + ~b + 1.
    assign lt_unsigned = ~sum_ext[XLEN];
    assign lt_signed   = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: res = sum;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOR:  res = ~(a | b);
            OP_SLT:  res = {{(XLEN-1){1'b0}}, lt_signed};
            OP_SLTU: res = {{(XLEN-1){1'b0}}, lt_unsigned};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/shift_alu_exec.sv
module shift_alu_exec
    import shift_alu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int FUNC_W = 6,
    parameter int RIDX_W = 5,
    localparam int SHW   = $clog2(XLEN)
) (
    input  logic [FUNC_W-1:0] funct,
    input  logic [RIDX_W-1:0] rs_idx,
    input  logic [RIDX_W-1:0] rt_idx,
    input  logic [RIDX_W-1:0] rd_idx,
    input  logic [SHW-1:0]    shamt,
    input  logic              rot_sel,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    output logic [XLEN-1:0]   result,
    output logic              wr_en,
    output logic [1:0]        nop_kind,
    output logic              ovf_trap
);
    dec_t            dec;
    nop_e            nop_cls;
    logic [SHW-1:0]  amt;
    logic [XLEN-1:0] sh_res, ar_res;
    logic            ar_ovf;
    logic            cond_ok;

    shift_alu_decode #(.FUNC_W(FUNC_W), .RIDX_W(RIDX_W), .SHW(SHW)) u_decode (
        .funct    (funct),
        .rot_sel  (rot_sel),
        .rs_idx   (rs_idx),
        .rt_idx   (rt_idx),
        .rd_idx   (rd_idx),
        .shamt    (shamt),
        .dec      (dec),
        .nop_kind (nop_cls)
    );

    // Register amounts take only the low bits of the first operand.
    assign amt = dec.reg_amt ? rs_val[SHW-1:0] : shamt;

    shift_alu_shifter #(.XLEN(XLEN), .SHW(SHW)) u_shifter (
        .op  (dec.op),
        .amt (amt),
        .val (rt_val),
        .res (sh_res)
    );

    shift_alu_arith #(.XLEN(XLEN)) u_arith (
        .op  (dec.op),
        .a   (rs_val),
        .b   (rt_val),
        .res (ar_res),
        .ovf (ar_ovf)
    );

    always_comb begin
        if (is_shift(dec.op))
            result = sh_res;
        else if (is_alu(dec.op))
            result = ar_res;
        else if (dec.op == OP_MOVZ || dec.op == OP_MOVN)
            result = rs_val;
        else
            result = '0;
    end

    always_comb begin
        unique case (dec.op)
            OP_MOVZ: cond_ok = (rt_val == '0);
            OP_MOVN: cond_ok = (rt_val != '0);
            OP_NONE: cond_ok = 1'b0;
            default: cond_ok = 1'b1;
        endcase
    end

    assign ovf_trap = dec.trap_en & ar_ovf;
    assign wr_en    = cond_ok && !ovf_trap && (rd_idx != '0) && (nop_cls == NOP_NONE);
    assign nop_kind = nop_cls;
endmodule

// File: rtl/shift_alu_exec_chk.sv
module shift_alu_exec_chk #(
    parameter int XLEN   = 32,
    parameter int FUNC_W = 6,
    parameter int RIDX_W = 5
) (
    input logic [FUNC_W-1:0] funct,
    input logic [RIDX_W-1:0] rd_idx,
    input logic [XLEN-1:0]   rt_val,
    input logic [XLEN-1:0]   result,
    input logic              wr_en,
    input logic [1:0]        nop_kind,
    input logic              ovf_trap
);
    always_comb begin
        if (ovf_trap)
            a_r8_trap_blocks_write: assert (!wr_en) else $error("trap with write enabled");
        if (ovf_trap)
            a_r8_trap_only_signed: assert (6'(funct) == 6'h20 || 6'(funct) == 6'h22)
                else $error("trap on non-trapping function");
        if (rd_idx == '0)
            a_r13_rd_zero_no_write: assert (!wr_en) else $error("write to register zero");
        if (nop_kind != 2'd0)
            a_r2_nop_no_write: assert (!wr_en && 6'(funct) == 6'h00) else $error("no-op misreported");
        if (6'(funct) == 6'h0A && rt_val != '0)
            a_r11_movz_blocked: assert (!wr_en) else $error("conditional move wrote");
        if (6'(funct) == 6'h0B && rt_val == '0)
            a_r11_movn_blocked: assert (!wr_en) else $error("conditional move wrote");
        if (6'(funct) == 6'h2A || 6'(funct) == 6'h2B)
            a_r10_flag_bool: assert (result[XLEN-1:1] == '0) else $error("compare result not 0/1");
    end
endmodule

bind shift_alu_exec shift_alu_exec_chk #(.XLEN(XLEN), .FUNC_W(FUNC_W), .RIDX_W(RIDX_W)) u_chk (
    .funct    (funct),
    .rd_idx   (rd_idx),
    .rt_val   (rt_val),
    .result   (result),
    .wr_en    (wr_en),
    .nop_kind (nop_kind),
    .ovf_trap (ovf_trap)
);

// File: tb/test_shift_alu_exec.sv
module test_shift_alu_exec;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  funct;
    logic [4:0]  rs_idx, rt_idx, rd_idx, shamt;
    logic        rot_sel;
    logic [31:0] rs_val, rt_val, result;
    logic        wr_en, ovf_trap;
    logic [1:0]  nop_kind;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_alu_exec i_shift_alu_exec (
        .funct(funct), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx),
        .shamt(shamt), .rot_sel(rot_sel), .rs_val(rs_val), .rt_val(rt_val),
        .result(result), .wr_en(wr_en), .nop_kind(nop_kind), .ovf_trap(ovf_trap)
    );

    function automatic logic [31:0] rot_right(logic [31:0] x, int n);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) o[i] = x[(i + n) % 32];
        return o;
    endfunction

    function automatic logic [31:0] sar_ref(logic [31:0] x, int n);
        logic [31:0] o = x >> n;
        for (int i = 0; i < n; i++) o[31 - i] = x[31];
        return o;
    endfunction

    function automatic string fn_tag(logic [5:0] f);
        case (f)
            6'h00: return "R1";
            6'h02: return "R3";
            6'h03, 6'h07: return "R6";
            6'h04: return "R5";
            6'h06: return "R4";
            6'h0A, 6'h0B: return "R11";
            6'h20, 6'h21, 6'h22, 6'h23: return "R7";
            6'h24, 6'h25, 6'h26, 6'h27: return "R9";
            6'h2A, 6'h2B: return "R10";
            default: return "R14";
        endcase
    endfunction

    task automatic apply_and_check(logic [5:0] f, logic [4:0] rsi, logic [4:0] rti,
                                   logic [4:0] rdi, logic [4:0] sa, logic rs_sel,
                                   logic [31:0] a, logic [31:0] b);
        logic [31:0] e_res;
        logic        e_wr, e_trap, valid, cond;
        logic [1:0]  e_nop;
        longint      s;
        int          va;
        string       tag;
        @(posedge clk);
        funct = f; rs_idx = rsi; rt_idx = rti; rd_idx = rdi;
        shamt = sa; rot_sel = rs_sel; rs_val = a; rt_val = b;
        va = int'(a[4:0]);
        e_res = 32'h0; e_trap = 1'b0; valid = 1'b1; cond = 1'b1;
        case (f)
            6'h00: e_res = b << sa;
            6'h02: e_res = rs_sel ? rot_right(b, int'(sa)) : (b >> sa);
            6'h03: e_res = sar_ref(b, int'(sa));
            6'h04: e_res = b << va;
            6'h06: e_res = rs_sel ? rot_right(b, va) : (b >> va);
            6'h07: e_res = sar_ref(b, va);
            6'h0A: begin e_res = a; cond = (b == 0); end
            6'h0B: begin e_res = a; cond = (b != 0); end
            6'h20, 6'h21: begin
                e_res = a + b;
                s = longint'($signed(a)) + longint'($signed(b));
                e_trap = (f == 6'h20) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            6'h22, 6'h23: begin
                e_res = a - b;
                s = longint'($signed(a)) - longint'($signed(b));
                e_trap = (f == 6'h22) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            6'h24: e_res = a & b;
            6'h25: e_res = a | b;
            6'h26: e_res = a ^ b;
            6'h27: e_res = ~(a | b);
            6'h2A: e_res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6'h2B: e_res = (a < b) ? 32'd1 : 32'd0;
            default: valid = 1'b0;
        endcase
        e_nop = 2'd0;
        if (f == 6'h00 && rsi == 0 && rti == 0 && rdi == 0)
            e_nop = (sa == 5'd1) ? 2'd2 : (sa == 5'd3) ? 2'd3 : 2'd1;
        e_wr = valid && cond && !e_trap && (rdi != 0) && (e_nop == 2'd0);
        @(negedge clk);
        n_checks++;
        if (result !== e_res || wr_en !== e_wr || ovf_trap !== e_trap || nop_kind !== e_nop) begin
            if (ovf_trap !== e_trap) tag = "R8";
            else if (nop_kind !== e_nop) tag = "R2";
            else if (wr_en !== e_wr && rdi == 0) tag = "R13";
            else if ((f == 6'h02 && rs_sel && sa == 0) || (f == 6'h06 && rs_sel && va == 0)) tag = "R12";
            else tag = fn_tag(f);
            n_fail++;
            $display("FAIL %s funct=%h a=%h b=%h sa=%0d rot=%0d rd=%0d: actual res=%h wr=%0d trap=%0d nop=%0d expected res=%h wr=%0d trap=%0d nop=%0d",
                     tag, f, a, b, sa, rs_sel, rdi, result, wr_en, ovf_trap, nop_kind,
                     e_res, e_wr, e_trap, e_nop);
        end
    endtask

    initial begin
        logic [31:0] pats [8];
        logic [4:0]  amts [4];
        pats = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                 32'hFFFFFFFF, 32'h12345678, 32'hDEADBEE5, 32'hFFFFFFE0};
        amts = '{5'd0, 5'd1, 5'd13, 5'd31};
        funct = '0; rs_idx = '0; rt_idx = '0; rd_idx = '0;
        shamt = '0; rot_sel = 1'b0; rs_val = '0; rt_val = '0;
        repeat (3) @(posedge clk);
        // Idle inputs under reset: all-zero shift-left is a plain no-op (R2).
        apply_and_check(6'h00, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 32'h0, 32'h0);
        rst = 1'b0;
        // R2: every amount of the all-zero shift-left form.
        for (int k = 0; k < 32; k++)
            apply_and_check(6'h00, 5'd0, 5'd0, 5'd0, 5'(k), 1'b0, 32'hA5A5A5A5, 32'h0F0F0F0F);
        // R2 negative: non-zero rs index is an ordinary shift, not a no-op.
        apply_and_check(6'h00, 5'd4, 5'd0, 5'd0, 5'd3, 1'b0, 32'h0, 32'h0);
        // R12: rotates by zero, immediate and register forms.
        apply_and_check(6'h02, 5'd1, 5'd2, 5'd9, 5'd0, 1'b1, 32'h0, 32'hCAFEF00D);
        apply_and_check(6'h06, 5'd1, 5'd2, 5'd9, 5'd7, 1'b1, 32'hFFFFFFE0, 32'hCAFEF00D);
        // R1..R14 sweep: every function, operand pair, amount, selector and rd.
        for (int f = 0; f < 64; f++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int m = 0; m < 4; m++)
                        for (int r = 0; r < 2; r++)
                            for (int d = 0; d < 2; d++)
                                apply_and_check(6'(f), 5'd1, 5'd2, (d == 0) ? 5'd0 : 5'd7,
                                                amts[m], r[0], pats[i], pats[j]);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual run still active after %0d cycles, expected completion", WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule